// File: doc/BRIEF.md
# Sequential Program Block Loader

This block lets a host fill five internal configuration tables through a single 16-bit programming register. Each word the host writes is one of two kinds. A table-select command sets bit 15. It picks a target table and sets that table's write pointer to its start. A data word clears bit 15. Its lower 15 bits are stored at the current pointer position, and the pointer then moves to the next entry.

A ready flag provides the handshake. The flag falls as soon as a write is taken. It rises again after a fixed, parameterised number of cycles, once the word has taken effect. Software sets that cycle count so that completion stays well inside a 250 µs bound.

Writes count only while the device is idle, meaning the receive, transmit and auxiliary converter functions are all off. Any misuse is dropped and sets a sticky error flag. Misuse covers writing while busy, writing while not idle, running past the end of a table, and sending data before any table has been selected. A read port shows every table entry to the logic that consumes the configuration.

Top module: `prog_table_loader`

## Requirements
- R1: After reset, `ready` is 1, `err` is 0 and every table entry reads 0.
- R2: A command word with bit 15 set selects a table using bits 14..12. The patterns 0xx pick table 4, 100 picks table 0, 101 picks table 1, 110 picks table 2 and 111 picks table 3. The table's pointer is set to entry 0.
- R3: A data word, with bit 15 clear, writes its bits 14..0 into the selected table at the current pointer. Only one table entry changes.
- R4: After each stored data word the pointer moves up by one, so consecutive data words fill consecutive entries. Entries beyond the last one written keep their earlier contents.
- R5: A table-3 select that also has bit 10 set starts the pointer at entry SKIP_AT (default 11). Bit 10 has no effect when selecting any other table.
- R6: `ready` falls in the cycle after an accepted write. It stays 0 for exactly DONE_CYCLES cycles, then returns to 1, and the word takes effect at that same edge.
- R7: A write while `ready` is 0 is ignored and sets `err`. The write already in progress still completes normally.
- R8: A write while `rx_on`, `tx_on` or `aux_on` is 1 is ignored, leaves `ready` at 1 and sets `err`.
- R9: A data word that would land at or past the table's word count (W_BLK0..W_BLK4) is dropped and sets `err`. The handshake still runs.
- R10: A data word that arrives before any table has been selected since reset is dropped and sets `err`.
- R11: Once `err` is set, it stays at 1 until reset.
- R12: Selecting a table again resets its pointer. Later data words then overwrite the table from its start position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_on | input | 1 | Receive function enabled |
| tx_on | input | 1 | Transmit function enabled |
| aux_on | input | 1 | Auxiliary converter enabled |
| wr_en | input | 1 | Host write strobe for the programming register |
| wr_data | input | 16 | Programming word |
| ready | output | 1 | 1 when a new write may be made |
| err | output | 1 | Sticky misuse flag |
| rd_blk | input | 3 | Table number for the read port |
| rd_idx | input | IDX_W | Entry index for the read port |
| rd_data | output | 15 | Entry contents (0 when the address is out of range) |

## Verification
The select path is tried with every bit 14..12 pattern, including two different 0xx forms. These tell the table-4 encoding apart from the others. They also show that a repeated select rewinds the pointer. Bit 10 is tried on table 3 and on table 0, which separates the skip entry from an ordinary start. Runs of data words that stop partway through a table, and a run that fills a table and then goes one word past its end, separate correct autoincrement from wrap-around or overrun. Misuse patterns are each checked after a fresh reset, so each one's effect on `err` and `ready` is seen on its own. These are writes while busy, writes with each of the three function enables on, and data before any select.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  localparam int unsigned NBLK   = 5;
  localparam int unsigned DATA_W = 15;

  typedef struct packed {
    logic              is_sel;
    logic [2:0]        blk;
    logic              skip;
    logic [DATA_W-1:0] data;
  } ptl_cmd_t;

  // bits 14..12 of a select word -> table number
  function automatic logic [2:0] sel_to_blk(input logic [2:0] f);
    if (!f[2]) return 3'd4;
    return {1'b0, f[1:0]};
  endfunction

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction
endpackage

// File: rtl/ptl_cmd_decode.sv
module ptl_cmd_decode
  import ptl_pkg::*;
(
  input  logic [15:0] word,
  output ptl_cmd_t    cmd
);
  always_comb begin
    cmd.is_sel = word[15];
    cmd.blk    = sel_to_blk(word[14:12]);
    cmd.skip   = word[15] & word[10] & (word[14:12] == 3'b111);
    cmd.data   = word[14:0];
  end
endmodule

// File: rtl/ptl_busy_timer.sv
module ptl_busy_timer #(
  parameter int unsigned LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready,
  output logic fire
);
  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (ready) begin
      if (start) begin
        ready <= 1'b0;
        cnt   <= CW'(LAT - 1);
      end
    end else if (cnt == '0) begin
      ready <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign fire = !ready && (cnt == '0);
endmodule

// File: rtl/ptl_pointer.sv
module ptl_pointer #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned SKIP_AT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_sel,
  input  logic [2:0]       sel_blk,
  input  logic             skip,
  input  logic [IDX_W-1:0] cur_limit,
  output logic [2:0]       cur_blk,
  output logic [IDX_W-1:0] ptr,
  output logic             ptr_valid,
  output logic             store,
  output logic             reject
);
  logic is_data;

  assign is_data = fire && !is_sel;
  assign store   = is_data && ptr_valid && (ptr < cur_limit);
  assign reject  = is_data && !store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_blk   <= '0;
      ptr       <= '0;
      ptr_valid <= 1'b0;
    end else if (fire && is_sel) begin
      cur_blk   <= sel_blk;
      ptr       <= skip ? IDX_W'(SKIP_AT) : '0;
      ptr_valid <= 1'b1;
    end else if (store) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ptl_table.sv
module ptl_table #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned DW    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we && (widx < IDX_W'(DEPTH))) begin
      mem[widx[AW-1:0]] <= wdata;
    end
  end

  assign rdata = (ridx < IDX_W'(DEPTH)) ? mem[ridx[AW-1:0]] : '0;
endmodule

// File: rtl/prog_table_loader.sv
module prog_table_loader
  import ptl_pkg::*;
#(
  parameter int unsigned W_BLK0      = 12,
  parameter int unsigned W_BLK1      = 12,
  parameter int unsigned W_BLK2      = 12,
  parameter int unsigned W_BLK3      = 24,
  parameter int unsigned W_BLK4      = 14,
  parameter int unsigned SKIP_AT     = 11,
  parameter int unsigned DONE_CYCLES = 16,
  parameter int unsigned IDX_W       = $clog2(max5(W_BLK0, W_BLK1, W_BLK2, W_BLK3, W_BLK4) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              tx_on,
  input  logic              aux_on,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic              ready,
  output logic              err,
  input  logic [2:0]        rd_blk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  function automatic int unsigned depth_of(input int unsigned b);
    case (b)
      0:       return W_BLK0;
      1:       return W_BLK1;
      2:       return W_BLK2;
      3:       return W_BLK3;
      default: return W_BLK4;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] limit_of(input logic [2:0] b);
    if (b > 3'd4) return '0;
    return IDX_W'(depth_of(int'(b)));
  endfunction

  // named internal events
  logic              idle, accept, refused, fire, store, reject, ptr_valid;
  logic [15:0]       pend;
  ptl_cmd_t          cmd;
  logic [2:0]        cur_blk;
  logic [IDX_W-1:0]  ptr, cur_limit;
  logic [NBLK-1:0]   tbl_we;
  logic [DATA_W-1:0] rdat [NBLK];

  assign idle    = !(rx_on || tx_on || aux_on);
  assign accept  = wr_en && ready && idle;
  assign refused = wr_en && !(ready && idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= '0;
    else if (accept) pend <= wr_data;
  end

  ptl_cmd_decode u_dec (.word(pend), .cmd(cmd));

  ptl_busy_timer #(.LAT(DONE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .ready(ready), .fire(fire)
  );

  assign cur_limit = limit_of(cur_blk);

  ptl_pointer #(.IDX_W(IDX_W), .SKIP_AT(SKIP_AT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .is_sel(cmd.is_sel), .sel_blk(cmd.blk), .skip(cmd.skip),
    .cur_limit(cur_limit), .cur_blk(cur_blk), .ptr(ptr),
    .ptr_valid(ptr_valid), .store(store), .reject(reject)
  );

  for (genvar b = 0; b < int'(NBLK); b++) begin : g_tbl
    assign tbl_we[b] = store && (cur_blk == 3'(b));
    ptl_table #(.DEPTH(depth_of(b)), .IDX_W(IDX_W), .DW(DATA_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we[b]), .widx(ptr), .wdata(cmd.data),
      .ridx(rd_idx), .rdata(rdat[b])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < int'(NBLK); b++)
      if (rd_blk == 3'(b)) rd_data = rdat[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err <= 1'b0;
    else if (refused || reject) err <= 1'b1;
  end
endmodule

// File: rtl/ptl_checker.sv
module ptl_checker #(
  parameter int unsigned LAT   = 16,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned NBLK  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             ready,
  input logic             idle,
  input logic             err,
  input logic             fire,
  input logic             reject,
  input logic             ptr_valid,
  input logic [IDX_W-1:0] ptr,
  input logic [IDX_W-1:0] cur_limit,
  input logic [NBLK-1:0]  tbl_we
);
  int unsigned lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lowcnt <= 0;
    else if (ready) lowcnt <= 0;
    else            lowcnt <= lowcnt + 1;
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready && idle) |=> !ready); // R6
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (lowcnt < LAT)); // R6
  AST_FIRE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (lowcnt == LAT - 1)); // R6
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> err); // R7
  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready && !idle) |=> (ready && err)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid |-> (ptr <= cur_limit)); // R9
  AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11
  AST_SINGLE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_we)); // R3
  AST_STORE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|tbl_we) |=> (ptr == IDX_W'($past(ptr) + 1'b1))); // R4
endmodule

bind prog_table_loader ptl_checker #(.LAT(DONE_CYCLES), .IDX_W(IDX_W), .NBLK(NBLK)) u_ptl_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ready(ready), .idle(idle), .err(err),
  .fire(fire), .reject(reject), .ptr_valid(ptr_valid), .ptr(ptr),
  .cur_limit(cur_limit), .tbl_we(tbl_we)
);

// File: tb/prog_table_loader_bench.sv
module prog_table_loader_bench;
  localparam int LAT  = 16;
  localparam int SKIP = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_on = 1'b0, tx_on = 1'b0, aux_on = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ready, err;
  logic [2:0]  rd_blk = '0;
  logic [4:0]  rd_idx = '0;
  logic [14:0] rd_data;

  always #4 clk = ~clk;

  prog_table_loader u_prog_table_loader (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .tx_on(tx_on), .aux_on(aux_on),
    .wr_en(wr_en), .wr_data(wr_data), .ready(ready), .err(err),
    .rd_blk(rd_blk), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int       lim[5] = '{12, 12, 12, 24, 14};
  int       m_mem[5][24];
  bit       m_ready, m_err, m_valid;
  int       m_blk, m_ptr, m_cnt;
  bit [15:0] m_pend;

  function automatic int blk_of(input bit [15:0] w);
    if (w[14] == 1'b0) return 4;
    return int'(w[13:12]);
  endfunction

  task automatic m_apply();
    if (m_pend[15]) begin
      m_blk   = blk_of(m_pend);
      m_ptr   = (m_blk == 3 && m_pend[10]) ? SKIP : 0;
      m_valid = 1;
    end else if (!m_valid || m_ptr >= lim[m_blk]) begin
      m_err = 1;
    end else begin
      m_mem[m_blk][m_ptr] = int'(m_pend[14:0]);
      m_ptr++;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 1; m_err = 0; m_valid = 0; m_blk = 0; m_ptr = 0; m_cnt = 0; m_pend = '0;
      foreach (m_mem[i, j]) m_mem[i][j] = 0;
    end else begin
      bit old;
      old = m_ready;
      if (!old) begin
        m_cnt--;
        if (m_cnt == 0) begin m_apply(); m_ready = 1; end
      end
      if (wr_en) begin
        if (!old || rx_on || tx_on || aux_on) m_err = 1;
        else begin m_pend = wr_data; m_ready = 0; m_cnt = LAT; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6/R7/R8 ready vs model", int'(ready), int'(m_ready));
      chk("R11 err vs model", int'(err), int'(m_err));
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_write(input bit [15:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    while (!ready) @(negedge clk);
  endtask

  task automatic rd(input int blk, input int idx, input int exp, input string tag);
    @(negedge clk); rd_blk = 3'(blk); rd_idx = 5'(idx);
    #1;
    chk(tag, int'(rd_data), exp);
    chk({tag, " vs model"}, int'(rd_data), m_mem[blk][idx]);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1200000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    int n;
    do_reset();
    // R1: reset state
    @(negedge clk);
    chk("R1 ready after reset", int'(ready), 1);
    chk("R1 err after reset", int'(err), 0);
    rd(0, 0, 0, "R1 table0 entry0 zero");
    rd(3, 23, 0, "R1 table3 last zero");

    // R6: exact busy window
    @(negedge clk); wr_en = 1'b1; wr_data = 16'hC000;
    @(negedge clk); wr_en = 1'b0;
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk("R6 ready low cycles", n, LAT);

    // R3 R4: partial fill of table 0
    host_write(16'h0111); host_write(16'h0222); host_write(16'h0333);
    rd(0, 0, 16'h111, "R3 t0[0]");
    rd(0, 2, 16'h333, "R4 t0[2]");
    rd(0, 3, 0, "R4 t0[3] untouched");
    rd(1, 0, 0, "R3 other table untouched");

    // R2: encodings
    host_write(16'h8000); host_write(16'h00A1);
    rd(4, 0, 16'hA1, "R2 0xx selects table4");
    host_write(16'hB000); host_write(16'h00A2);
    rd(4, 0, 16'hA2, "R2 R12 other 0xx form reselects table4 at 0");
    rd(4, 1, 0, "R12 table4[1] untouched");
    host_write(16'hD000); host_write(16'h00D1);
    rd(1, 0, 16'hD1, "R2 101 selects table1");
    host_write(16'hE000); host_write(16'h00E1);
    rd(2, 0, 16'hE1, "R2 110 selects table2");
    host_write(16'hF000); host_write(16'h00F1);
    rd(3, 0, 16'hF1, "R2 111 selects table3");

    // R5: skip entry
    host_write(16'hF400); host_write(16'h0555); host_write(16'h0556);
    rd(3, SKIP, 16'h555, "R5 skip start");
    rd(3, SKIP + 1, 16'h556, "R5 skip then advance");
    rd(3, 1, 0, "R5 skipped entry untouched");
    host_write(16'hC400); host_write(16'h0444);
    rd(0, 0, 16'h444, "R5 bit10 no effect on table0");
    rd(0, 1, 16'h222, "R12 table0[1] kept");
    chk("R1 no error so far", int'(err), 0);

    // R9: overflow
    host_write(16'hD000);
    for (int i = 0; i < 12; i++) host_write(16'(100 + i));
    chk("R9 no error at full table", int'(err), 0);
    host_write(16'h0999);
    chk("R9 overflow sets err", int'(err), 1);
    rd(1, 11, 111, "R9 last entry intact");

    // R10 R11
    do_reset();
    host_write(16'h0042);
    chk("R10 data before select err", int'(err), 1);
    rd(0, 0, 0, "R10 nothing stored");
    host_write(16'hC000); host_write(16'h0043);
    rd(0, 0, 16'h43, "R11 later writes still work");
    repeat (5) @(negedge clk);
    chk("R11 err stays set", int'(err), 1);

    // R7: write while busy
    do_reset();
    @(negedge clk); wr_en = 1'b1; wr_data = 16'hC000;
    @(negedge clk); wr_data = 16'h0777;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 busy write sets err", int'(err), 1);
    while (!ready) @(negedge clk);
    rd(0, 0, 0, "R7 refused data not stored");
    host_write(16'h0778);
    rd(0, 0, 16'h778, "R7 original select completed");

    // R8: each enable
    for (int k = 0; k < 3; k++) begin
      do_reset();
      @(negedge clk);
      rx_on = (k == 0); tx_on = (k == 1); aux_on = (k == 2);
      wr_en = 1'b1; wr_data = 16'hC000;
      @(negedge clk); wr_en = 1'b0;
      chk("R8 ready stays high when not idle", int'(ready), 1);
      chk("R8 err when not idle", int'(err), 1);
      rx_on = 1'b0; tx_on = 1'b0; aux_on = 1'b0;
      host_write(16'h0066);
      rd(0, 0, 0, "R8 ignored select leaves no table");
    end

    summary();
  end
endmodule